// File: doc/BRIEF.md
# SHA-256 Message Schedule Update Unit

This unit advances the SHA-256 message schedule by four words per operation. The caller keeps the sixteen-word schedule window in four 128-bit vectors, each holding four 32-bit words with word 0 in bits 31:0. Each operation works on some of those vectors and returns four new 32-bit words packed the same way. The unit does not hold the window itself.

The unit has two steps, chosen by `opSel`. In the first step, each lane of the old destination vector `opA` gets the small-sigma0 mix of the next word in sequence added to it. That next word is taken from a window shifted by one lane across `opA` and `opB`. The second step finishes the update. It adds a lane-shifted word taken across `opB` and `opC`, plus the small-sigma1 mix of words two positions back. The two high lanes of the second step take those earlier words from the two low lanes that the same step has just produced. Those lanes therefore form a serial chain within one operation.

Operands are sampled on the rising edge where `inValid` is high. The result appears in a register on the following cycle, with a one-cycle `outValid` strobe. Between operations the register holds its value.

Top module: `sched_update_top`

## Requirements
- R1: While `rst` is high at a rising edge, `outValid` is cleared to 0 and `result` to all zeros. Both stay that way until an operation is accepted.
- R2: `outValid` is high in exactly the cycles that follow an edge at which `inValid` was high. Back-to-back operations give back-to-back strobes, with no extra or missing pulse.
- R3: With `opSel`=0 (first step), lane e of `result` (bits 32e+31:32e, lane 0 at 31:0) equals s0(W_e) + `opA` lane e modulo 2^32. W = {`opB`[31:0], `opA`[127:32]}. s0(x) = ror(x,7) ^ ror(x,18) ^ (x >> 3).
- R4: In the first step, lane 3 draws its sigma input from `opB` lane 0 (bits 31:0). For example, `opA`=0 with `opB` lane 0 = 1 gives lane 3 = 0x02004000 and all other lanes 0.
- R5: With `opSel`=1 (second step), lanes 0 and 1 of `result` equal s1(`opC` lane e+2) + `opA` lane e + V_e modulo 2^32. V = {`opC`[31:0], `opB`[127:32]}. s1(x) = ror(x,17) ^ ror(x,19) ^ (x >> 10).
- R6: In the second step, lanes 2 and 3 equal s1(result lane e-2) + `opA` lane e + V_e. They use the lanes 0 and 1 produced by the same operation. For example, `opC` lane 2 = 1 with everything else 0 gives lanes {3,2,1,0} = {0, 0x44000028, 0, 0x0000A000}.
- R7: In the second step, V lane 3 is `opC` lane 0. For example, `opC` lane 0 = 5 with everything else 0 gives lane 3 = 5 and the other lanes 0.
- R8: In the first step, `opC` has no effect on `result`.
- R9: When `inValid` is low at an edge, `result` keeps its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Accept the operands on this edge |
| opSel | input | 1 | 0 = first step (sigma0), 1 = second step (sigma1) |
| opA | input | 128 | Old destination vector, lanes summed into the result |
| opB | input | 128 | Second operand vector |
| opC | input | 128 | Third operand vector, used only by the second step |
| outValid | output | 1 | One-cycle strobe: `result` holds a new value |
| result | output | 128 | Four new schedule words, lane 0 in bits 31:0 |

## Verification
A wrong lane slice or shift amount in the datapath shows up as a wrong `result` word in the very cycle the strobe rises. The directed single-bit patterns show which lane is affected and where the bit came from. A broken chain between the low and high lanes of the second step corrupts only lanes 2 and 3 while lanes 0 and 1 stay correct, so that fault is told apart from a plain sigma fault. A control error shows as a strobe that arrives a cycle early, a cycle late or not at all, or as a result register that drifts during idle cycles. Both are caught at the first cycle where they happen.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int WORD_W = 32;
  localparam int LANES = 4;
  localparam int VEC_W = WORD_W * LANES;
  localparam int HALF = LANES / 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic capture;
    logic useSigma1;
  } ctrl_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t smallSig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smallSig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  input  logic  opSel,
  output ctrl_t ctrl,
  output logic  outValid
);
  always_comb begin
    ctrl.capture   = inValid;
    ctrl.useSigma1 = opSel;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  vec_t  opA,
  input  vec_t  opB,
  input  vec_t  opC,
  output vec_t  result
);
  vec_t winS0;
  vec_t winS1;
  logic [LANES-1:0][WORD_W-1:0] laneS0;
  logic [LANES-1:0][WORD_W-1:0] laneS1;

  assign winS0 = {opB[WORD_W-1:0], opA[VEC_W-1:WORD_W]};
  assign winS1 = {opC[WORD_W-1:0], opB[VEC_W-1:WORD_W]};

  for (genvar g = 0; g < LANES; g++) begin : gLaneS0
    assign laneS0[g] = smallSig0(winS0[g*WORD_W +: WORD_W]) + opA[g*WORD_W +: WORD_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : gLaneS1
    if (g < HALF) begin : gLow
      assign laneS1[g] = smallSig1(opC[(g+HALF)*WORD_W +: WORD_W])
                       + opA[g*WORD_W +: WORD_W] + winS1[g*WORD_W +: WORD_W];
    end else begin : gHigh
      assign laneS1[g] = smallSig1(laneS1[g-HALF])
                       + opA[g*WORD_W +: WORD_W] + winS1[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (ctrl.capture) result <= ctrl.useSigma1 ? vec_t'(laneS1) : vec_t'(laneS0);
  end
endmodule

// File: rtl/sched_update_top.sv
module sched_update_top
  import sched_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         opSel,
  input  logic [127:0] opA,
  input  logic [127:0] opB,
  input  logic [127:0] opC,
  output logic         outValid,
  output logic [127:0] result
);
  ctrl_t ctrl;

  sched_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .ctrl(ctrl), .outValid(outValid)
  );

  sched_datapath uDp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .opA(opA), .opB(opB), .opC(opC), .result(result)
  );
endmodule

// File: rtl/sched_update_chk.sv
module sched_update_chk
  import sched_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         opSel,
  input logic [127:0] opA,
  input logic [127:0] opB,
  input logic [127:0] opC,
  input logic         outValid,
  input logic [127:0] result
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && result == '0));

  // R2
  strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R2
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  // R6
  chain_lane2_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel) |=>
      result[95:64] == smallSig1(result[31:0]) + $past(opA[95:64]) + $past(opB[127:96]));
endmodule

bind sched_update_top sched_update_chk uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
  .opA(opA), .opB(opB), .opC(opC), .outValid(outValid), .result(result)
);

// File: tb/tb_sched_update_top.sv
module tb_sched_update_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic opSel = 1'b0;
  logic [127:0] opA = '0, opB = '0, opC = '0;
  logic outValid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  logic [127:0] expQ[$];
  string tagQ[$];
  logic [127:0] lastRes;
  logic haveLast = 1'b0;
  logic monOn = 1'b0;

  always #2.5 clk = ~clk;

  sched_update_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .opC(opC), .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d = {x, x};
    return d[n +: 32];
  endfunction

  function automatic logic [31:0] lw(input logic [127:0] v, input int i);
    return v[32*i +: 32];
  endfunction

  function automatic logic [127:0] model(input logic s, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    logic [31:0] r[4];
    logic [31:0] nxt, sg;
    for (int e = 0; e < 4; e++) begin
      if (!s) begin
        nxt = (e == 3) ? lw(b, 0) : lw(a, e + 1);
        r[e] = (rr(nxt, 7) ^ rr(nxt, 18) ^ (nxt >> 3)) + lw(a, e);
      end else begin
        nxt = (e == 3) ? lw(c, 0) : lw(b, e + 1);
        sg = (e < 2) ? lw(c, e + 2) : r[e - 2];
        r[e] = (rr(sg, 17) ^ rr(sg, 19) ^ (sg >> 10)) + lw(a, e) + nxt;
      end
    end
    return {r[3], r[2], r[1], r[0]};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic s, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] c,
                       input logic [127:0] direct, input logic useDirect);
    @(negedge clk);
    inValid = 1'b1; opSel = s; opA = a; opB = b; opC = c;
    expQ.push_back(useDirect ? direct : model(s, a, b, c));
    tagQ.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opSel = ~opSel; opA = {4{$urandom}}; opB = {4{$urandom}}; opC = {4{$urandom}};
    end
  endtask

  // Monitor: strobe timing (R2), scoreboard compare, hold check (R9)
  always @(posedge clk) begin
    #1;
    if (monOn) begin
      checks++;
      if (outValid !== inValid) begin
        errors++;
        $display("FAIL R2: actual outValid %b expected %b", outValid, inValid);
      end
    end
    if (monOn && outValid) begin
      if (expQ.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: actual extra result %h expected none", result);
      end else begin
        check(tagQ.pop_front(), result, expQ.pop_front());
      end
      lastRes = result; haveLast = 1'b1;
    end else if (monOn && haveLast) begin
      check("R9", result, lastRes);
    end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {127'(0), outValid}, '0);
    check("R1", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", result, '0);
    monOn = 1'b1;

    issue("R4", 1'b0, '0, 128'h1, '0, {32'h02004000, 96'h0}, 1'b1);
    idle(1);
    issue("R6", 1'b1, '0, '0, {32'h0, 32'h1, 64'h0},
          {32'h0, 32'h44000028, 32'h0, 32'h0000A000}, 1'b1);
    issue("R7", 1'b1, '0, '0, 128'h5, {32'h5, 96'h0}, 1'b1);
    idle(3);
    // R3 / R5: random back-to-back, both steps
    for (int k = 0; k < 12; k++) begin
      issue(k[0] ? "R5" : "R3", k[0], {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, '0, 1'b0);
    end
    idle(2);
    // R8: same opA/opB, two different opC in step 1 -> identical result
    begin
      logic [127:0] a = {4{$urandom}}, b = {4{$urandom}};
      issue("R8", 1'b0, a, b, '0, model(1'b0, a, b, '0), 1'b1);
      idle(1);
      issue("R8", 1'b0, a, b, '1, model(1'b0, a, b, '0), 1'b1);
    end
    idle(4);
    // R6: random chained second step
    for (int k = 0; k < 4; k++) begin
      issue("R6", 1'b1, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, '0, 1'b0);
      idle(k);
    end
    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d results missing expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule